// File: doc/BRIEF.md
# USB Charger Detection Sequencer

This block runs the digital half of USB battery charger detection on the peripheral side of a transceiver. Analog comparators report three things as plain logic levels: bus power is valid, DM is above the data-detect level, and DM is above the illegal-device level. A slow 1 kHz tick paces every detection timer. When power arrives and automatic detection is allowed, the sequencer turns on the DP voltage source and the DM current sink. It lets the lines settle for a set number of ticks and then samples DM once. The sample decides between three results: a charger is present, an illegal device is present, or the pass is repeated after a pause.

Automatic detection is allowed by an active-low pin. A register bit can also turn on the DP source by hand, whether or not automatic detection is allowed. When that bit is cleared, a busy indication stays up for a set number of system clocks. This covers the time the analog circuit needs to shut down fully, so software waits on it before it enables the DP pull-up.

Top module: `usb_chg_detect`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it, all five outputs are low.
- R2: With `autoEnN` low and `vbusValid` high, a pass starts from idle. `dpSrcEn` and `dmSinkEn` rise together and stay high for SETTLE_TICKS tick pulses, then DM is sampled once.
- R3: If the sample sees `dmAboveData` high and `dmAboveIllegal` low, `chargerFound` goes high and both enables drop. No further pass runs, and the flag stays high while `vbusValid` stays high.
- R4: While `autoEnN` is high, no pass starts. A pass in progress is abandoned at the next clock, with its enables dropped.
- R5: If the sample sees both DM comparators low, the enables stay low for RETRY_TICKS tick pulses (1000, one second, by default) and then a new pass starts. This repeats with no limit.
- R6: If the sample sees `dmAboveIllegal` high, `illegalDev` goes high whatever `dmAboveData` shows, and `chargerFound` stays low. No further pass runs until `vbusValid` falls and rises again.
- R7: One clock after `vbusValid` is sampled low, `dmSinkEn`, `chargerFound` and `illegalDev` are low, and `dpSrcEn` follows only `manSrcEn`.
- R8: `manSrcEn` high drives `dpSrcEn` high whatever `autoEnN` and `vbusValid` are. It never raises `dmSinkEn`.
- R9: After `manSrcEn` is sampled low following a high sample, `disBusy` is high for exactly DIS_CYCLES clock cycles, starting in the next cycle. If `manSrcEn` is sampled high again, `disBusy` drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick1k | input | 1 | One-clock pulse at 1 kHz, the detection timebase |
| autoEnN | input | 1 | Automatic detection allowed when low |
| manSrcEn | input | 1 | Register bit that enables the DP source by hand |
| vbusValid | input | 1 | Bus power comparator |
| dmAboveData | input | 1 | DM above the data-detect level |
| dmAboveIllegal | input | 1 | DM above the illegal-device level |
| dpSrcEn | output | 1 | DP voltage source enable |
| dmSinkEn | output | 1 | DM current sink enable (automatic passes only) |
| chargerFound | output | 1 | Sticky charger-detected status |
| illegalDev | output | 1 | Sticky illegal-device status |
| disBusy | output | 1 | Detection circuit still settling after a manual disable |

## Verification
The bound checker watches, on every cycle, the properties that follow from a single clock step. A pass may only start with automatic detection allowed and power present. A power drop clears the sink and both flags one clock later. The two flags never coexist, and a sticky result keeps the sink off. Clearing the manual bit raises the busy signal. The lengths of the settle window, the retry pause and the busy window, the repeated retries, and the fall-and-rise exit from the illegal-device lockout need many cycles of history. The bench's scenarios show these by counting tick pulses and cycles at the ports.

// File: rtl/chg_det_pkg.sv
package chg_det_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOURCE,
    ST_SENSE,
    ST_FOUND,
    ST_RETRY,
    ST_LOCK
  } detState_t;

  // strobes from the sequencer to the timer/flag datapath
  typedef struct packed {
    logic clrTicks;
    logic setFound;
    logic setIllegal;
    logic clrFlags;
  } dpStrobe_t;

endpackage

// File: rtl/chg_det_ctrl.sv
module chg_det_ctrl
  import chg_det_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      autoEnN,
  input  logic      vbusValid,
  input  logic      dmAboveData,
  input  logic      dmAboveIllegal,
  input  logic      settleDone,
  input  logic      retryDone,
  output dpStrobe_t strobe,
  output logic      srcActive
);

  detState_t state, nextState;

  always_comb begin
    nextState        = state;
    strobe           = '0;
    strobe.clrFlags  = !vbusValid;
    if (!vbusValid) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!autoEnN) begin
            nextState       = ST_SOURCE;
            strobe.clrTicks = 1'b1;
          end
        end
        ST_SOURCE: begin
          if (autoEnN)         nextState = ST_IDLE;
          else if (settleDone) nextState = ST_SENSE;
        end
        ST_SENSE: begin
          if (autoEnN) begin
            nextState = ST_IDLE;
          end else if (dmAboveIllegal) begin
            // over-voltage check takes priority over the data level
            nextState         = ST_LOCK;
            strobe.setIllegal = 1'b1;
          end else if (dmAboveData) begin
            nextState       = ST_FOUND;
            strobe.setFound = 1'b1;
          end else begin
            nextState       = ST_RETRY;
            strobe.clrTicks = 1'b1;
          end
        end
        ST_RETRY: begin
          if (autoEnN) begin
            nextState = ST_IDLE;
          end else if (retryDone) begin
            nextState       = ST_SOURCE;
            strobe.clrTicks = 1'b1;
          end
        end
        ST_FOUND: nextState = ST_FOUND;
        ST_LOCK:  nextState = ST_LOCK;
        default:  nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  assign srcActive = (state == ST_SOURCE) || (state == ST_SENSE);

endmodule

// File: rtl/chg_det_dp.sv
module chg_det_dp
  import chg_det_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 40,
  parameter int unsigned RETRY_TICKS  = 1000,
  parameter int unsigned DIS_CYCLES   = 40000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick1k,
  input  logic      manSrcEn,
  input  dpStrobe_t strobe,
  output logic      settleDone,
  output logic      retryDone,
  output logic      chargerFound,
  output logic      illegalDev,
  output logic      disBusy
);

  localparam int unsigned TICK_MAX = (SETTLE_TICKS > RETRY_TICKS) ? SETTLE_TICKS : RETRY_TICKS;
  localparam int unsigned TICK_W   = $clog2(TICK_MAX + 1);
  localparam int unsigned DIS_W    = $clog2(DIS_CYCLES + 1);

  logic [TICK_W-1:0] tickCnt;
  logic [DIS_W-1:0]  disCnt;
  logic              manPrev;

  // tick counter, saturating at the longest window
  always_ff @(posedge clk) begin
    if (rst || strobe.clrTicks)
      tickCnt <= '0;
    else if (tick1k && (tickCnt != TICK_W'(TICK_MAX)))
      tickCnt <= tickCnt + 1'b1;
  end

  assign settleDone = (tickCnt >= TICK_W'(SETTLE_TICKS));
  assign retryDone  = (tickCnt >= TICK_W'(RETRY_TICKS));

  // sticky result flags
  always_ff @(posedge clk) begin
    if (rst || strobe.clrFlags) begin
      chargerFound <= 1'b0;
      illegalDev   <= 1'b0;
    end else begin
      if (strobe.setFound)   chargerFound <= 1'b1;
      if (strobe.setIllegal) illegalDev   <= 1'b1;
    end
  end

  // disable settling window, counted in system clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      manPrev <= 1'b0;
      disCnt  <= '0;
    end else begin
      manPrev <= manSrcEn;
      if (manSrcEn)
        disCnt <= '0;
      else if (manPrev)
        disCnt <= DIS_W'(DIS_CYCLES);
      else if (disCnt != '0)
        disCnt <= disCnt - 1'b1;
    end
  end

  assign disBusy = (disCnt != '0);

endmodule

// File: rtl/usb_chg_detect.sv
module usb_chg_detect
  import chg_det_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 40,
  parameter int unsigned RETRY_TICKS  = 1000,
  parameter int unsigned DIS_CYCLES   = 40000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick1k,
  input  logic autoEnN,
  input  logic manSrcEn,
  input  logic vbusValid,
  input  logic dmAboveData,
  input  logic dmAboveIllegal,
  output logic dpSrcEn,
  output logic dmSinkEn,
  output logic chargerFound,
  output logic illegalDev,
  output logic disBusy
);

  dpStrobe_t strobe;
  logic      settleDone;
  logic      retryDone;
  logic      srcActive;

  chg_det_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .autoEnN        (autoEnN),
    .vbusValid      (vbusValid),
    .dmAboveData    (dmAboveData),
    .dmAboveIllegal (dmAboveIllegal),
    .settleDone     (settleDone),
    .retryDone      (retryDone),
    .strobe         (strobe),
    .srcActive      (srcActive)
  );

  chg_det_dp #(
    .SETTLE_TICKS (SETTLE_TICKS),
    .RETRY_TICKS  (RETRY_TICKS),
    .DIS_CYCLES   (DIS_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .tick1k       (tick1k),
    .manSrcEn     (manSrcEn),
    .strobe       (strobe),
    .settleDone   (settleDone),
    .retryDone    (retryDone),
    .chargerFound (chargerFound),
    .illegalDev   (illegalDev),
    .disBusy      (disBusy)
  );

  assign dpSrcEn  = srcActive | manSrcEn;
  assign dmSinkEn = srcActive;

endmodule

// File: rtl/chg_detect_checker.sv
module chg_detect_checker (
  input logic clk,
  input logic rst,
  input logic autoEnN,
  input logic manSrcEn,
  input logic vbusValid,
  input logic dmSinkEn,
  input logic chargerFound,
  input logic illegalDev,
  input logic disBusy
);

  // R4: a pass only starts when auto detection is allowed and power is present
  a_r4_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(dmSinkEn) |-> $past(!autoEnN && vbusValid));

  // R7: losing bus power clears the sink and the sticky flags one clock later
  a_r7_vbus_loss_clears: assert property (@(posedge clk) disable iff (rst)
    !vbusValid |=> (!dmSinkEn && !chargerFound && !illegalDev));

  // R6: the two results never coexist
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(chargerFound && illegalDev));

  // R3: a charger result only follows a pass with the sink on
  a_r3_found_after_pass: assert property (@(posedge clk) disable iff (rst)
    $rose(chargerFound) |-> $past(dmSinkEn));

  // R3: no pass runs while a charger result is held
  a_r3_found_silent: assert property (@(posedge clk) disable iff (rst)
    chargerFound |-> !dmSinkEn);

  // R6: lockout keeps the sink off
  a_r6_lock_silent: assert property (@(posedge clk) disable iff (rst)
    illegalDev |-> !dmSinkEn);

  // R9: clearing the manual bit raises the settling indication
  a_r9_busy_after_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(manSrcEn) |=> disBusy);

endmodule

bind usb_chg_detect chg_detect_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .autoEnN      (autoEnN),
  .manSrcEn     (manSrcEn),
  .vbusValid    (vbusValid),
  .dmSinkEn     (dmSinkEn),
  .chargerFound (chargerFound),
  .illegalDev   (illegalDev),
  .disBusy      (disBusy)
);

// File: tb/tb_usb_chg_detect.sv
`timescale 1ns/1ps
module tb_usb_chg_detect;

  localparam int SETTLE = 4;
  localparam int RETRY  = 6;
  localparam int DISC   = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick1k = 1'b0;
  logic autoEnN = 1'b1;
  logic manSrcEn = 1'b0;
  logic vbusValid = 1'b0;
  logic dmAboveData = 1'b0;
  logic dmAboveIllegal = 1'b0;
  logic dpSrcEn, dmSinkEn, chargerFound, illegalDev, disBusy;

  int nChecks = 0;
  int nFails  = 0;
  int tickDiv = 0;

  always #2.5 clk = ~clk;

  usb_chg_detect #(
    .SETTLE_TICKS (SETTLE),
    .RETRY_TICKS  (RETRY),
    .DIS_CYCLES   (DISC)
  ) dut (
    .clk (clk), .rst (rst), .tick1k (tick1k), .autoEnN (autoEnN),
    .manSrcEn (manSrcEn), .vbusValid (vbusValid), .dmAboveData (dmAboveData),
    .dmAboveIllegal (dmAboveIllegal), .dpSrcEn (dpSrcEn), .dmSinkEn (dmSinkEn),
    .chargerFound (chargerFound), .illegalDev (illegalDev), .disBusy (disBusy)
  );

  // one-clock tick every 8 clocks
  initial begin
    forever begin
      @(posedge clk); #1;
      tickDiv = (tickDiv == 7) ? 0 : tickDiv + 1;
      tick1k  = (tickDiv == 0);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // count ticks while the sink stays high; ends at first low sample
  task automatic measureHigh(output int ticks, output bit ok);
    ticks = 0; ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!dmSinkEn) begin ok = 1'b1; break; end
      if (tick1k) ticks++;
    end
  endtask

  task automatic measureLow(output int ticks, output bit ok);
    ticks = 0; ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (dmSinkEn) begin ok = 1'b1; break; end
      if (tick1k) ticks++;
    end
  endtask

  task automatic powerCycle();
    vbusValid = 1'b0;
    cycles(3);
    vbusValid = 1'b1;
  endtask

  task automatic testReset();
    rst = 1'b1;
    cycles(3);
    @(negedge clk);
    check(!dpSrcEn && !dmSinkEn && !chargerFound && !illegalDev && !disBusy,
          "R1", "outputs in reset", int'(dpSrcEn | dmSinkEn | chargerFound | illegalDev | disBusy), 0);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    check(!dpSrcEn && !dmSinkEn && !chargerFound && !illegalDev && !disBusy,
          "R1", "outputs after reset", int'(dpSrcEn | dmSinkEn | chargerFound | illegalDev | disBusy), 0);
  endtask

  task automatic testManual();
    int busy;
    @(posedge clk); #1;
    autoEnN = 1'b1; vbusValid = 1'b1;
    cycles(200);
    @(negedge clk);
    check(!dmSinkEn && !dpSrcEn, "R4", "no pass while disabled", int'(dmSinkEn), 0);
    @(posedge clk); #1; manSrcEn = 1'b1;
    cycles(2);
    @(negedge clk);
    check(dpSrcEn, "R8", "manual drives DP source", int'(dpSrcEn), 1);
    check(!dmSinkEn, "R8", "manual leaves sink off", int'(dmSinkEn), 0);
    @(posedge clk); #1; vbusValid = 1'b0;
    cycles(2);
    @(negedge clk);
    check(dpSrcEn, "R8", "manual without bus power", int'(dpSrcEn), 1);
    @(posedge clk); #1; manSrcEn = 1'b0;
    busy = 0;
    for (int i = 0; i < DISC + 20; i++) begin
      @(negedge clk);
      if (disBusy) busy++;
    end
    check(busy == DISC, "R9", "busy window length", busy, DISC);
    @(posedge clk); #1; manSrcEn = 1'b1;
    @(posedge clk); #1; manSrcEn = 1'b0;
    cycles(10);
    manSrcEn = 1'b1;
    @(negedge clk);
    check(disBusy, "R9", "busy before re-enable", int'(disBusy), 1);
    @(posedge clk);
    @(negedge clk);
    check(!disBusy, "R9", "re-enable cancels busy", int'(disBusy), 0);
    @(posedge clk); #1; manSrcEn = 1'b0;
    cycles(DISC + 5);
  endtask

  task automatic testRetry();
    int t; bit ok;
    @(posedge clk); #1;
    dmAboveData = 1'b0; dmAboveIllegal = 1'b0; autoEnN = 1'b0;
    powerCycle();
    measureLow(t, ok);
    check(ok && dpSrcEn, "R2", "pass starts with both enables", int'(dpSrcEn), 1);
    measureHigh(t, ok);
    check(ok && t == SETTLE, "R2", "settle ticks", t, SETTLE);
    measureLow(t, ok);
    check(ok && t == RETRY, "R5", "retry pause ticks", t, RETRY);
    measureHigh(t, ok);
    check(ok && t == SETTLE, "R5", "second pass settle ticks", t, SETTLE);
    measureLow(t, ok);
    check(ok && t == RETRY, "R5", "second retry pause", t, RETRY);
    check(!chargerFound && !illegalDev, "R5", "no result on empty pass", int'(chargerFound), 0);
  endtask

  task automatic testFound();
    int t; bit ok;
    @(posedge clk); #1;
    dmAboveData = 1'b1; dmAboveIllegal = 1'b0; autoEnN = 1'b0;
    powerCycle();
    measureLow(t, ok);
    measureHigh(t, ok);
    check(ok && chargerFound && !illegalDev, "R3", "charger flagged", int'(chargerFound), 1);
    check(!dpSrcEn, "R3", "source off after result", int'(dpSrcEn), 0);
    @(posedge clk); #1; dmAboveData = 1'b0;
    cycles(RETRY * 8 * 3);
    @(negedge clk);
    check(chargerFound && !dmSinkEn, "R3", "result sticky, no retry", int'(chargerFound), 1);
    @(posedge clk); #1; vbusValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!chargerFound, "R7", "bus loss clears charger flag", int'(chargerFound), 1'b0);
  endtask

  task automatic testIllegal();
    int t; bit ok;
    @(posedge clk); #1;
    dmAboveData = 1'b1; dmAboveIllegal = 1'b1; autoEnN = 1'b0;
    powerCycle();
    measureLow(t, ok);
    measureHigh(t, ok);
    check(ok && illegalDev, "R6", "illegal flagged", int'(illegalDev), 1);
    check(!chargerFound, "R6", "illegal beats data level", int'(chargerFound), 0);
    @(posedge clk); #1; dmAboveData = 1'b0; dmAboveIllegal = 1'b0;
    cycles(RETRY * 8 * 3);
    @(negedge clk);
    check(illegalDev && !dmSinkEn, "R6", "locked out while powered", int'(dmSinkEn), 0);
    @(posedge clk); #1; vbusValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!illegalDev, "R7", "bus loss clears illegal flag", int'(illegalDev), 0);
    @(posedge clk); #1; vbusValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(dmSinkEn, "R6", "new pass after bus fall and rise", int'(dmSinkEn), 1);
  endtask

  task automatic testAbort();
    int t; bit ok;
    @(posedge clk); #1;
    dmAboveData = 1'b0; dmAboveIllegal = 1'b0; autoEnN = 1'b0;
    powerCycle();
    measureLow(t, ok);
    @(posedge clk); #1; vbusValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!dmSinkEn && !dpSrcEn, "R7", "bus loss drops enables", int'(dpSrcEn), 0);
    @(posedge clk); #1; vbusValid = 1'b1;
    measureLow(t, ok);
    check(ok, "R2", "restart after power", int'(dmSinkEn), 1);
    @(posedge clk); #1; autoEnN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(!dmSinkEn && !dpSrcEn, "R4", "disable abandons pass", int'(dmSinkEn), 0);
    cycles(RETRY * 8 * 2);
    @(negedge clk);
    check(!dmSinkEn, "R4", "stays idle while disabled", int'(dmSinkEn), 0);
  endtask

  initial begin
    testReset();
    testManual();
    testRetry();
    testFound();
    testIllegal();
    testAbort();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(100000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule